// File: doc/BRIEF.md
# Warm-Reboot Command Sequencer

This block tells an FPGA's internal configuration port to reload the device from a new flash image. A single-cycle trigger latches a 32-bit start address for the next image. The block then writes a fixed stream of configuration packets through a narrow word port. The port has a 32-bit data bus and active-low chip-enable and write-enable strobes. The stream is a dummy word, then the synchronization word, then a write of the start address into the warm-boot address register, and last the reload command.

A `busy` output is high while the stream goes out, and a one-cycle `done` pulse follows the last word. Triggers that arrive during a run are dropped. The parameter `SWAP` selects the bit order on the data bus. With `SWAP=1`, the bits inside every byte are reversed, for ports that expect that ordering.

Top module: `warmboot_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `cfg_cs_n` and `cfg_we_n` are 1, `busy` and `done` are 0, and `cfg_data` is 0.
- R2: A trigger accepted at edge k puts eight words on `cfg_data`, one after each of edges k..k+7, in this order: 0xFFFFFFFF, 0xAA995566, 0x20000000, 0x30020001, the latched address, 0x30008001, 0x0000000F, 0x20000000.
- R3: The address word is the value of `boot_addr` at the accepting edge, even if `boot_addr` changes during the run.
- R4: The command-write header (word 6) is a type-1 write: bits [31:29]=001 and bits [28:27]=10. Its 5-bit register field, bits [17:13], holds 0x04. The word after it carries 0x0F, the full-reload code.
- R5: `cfg_cs_n` and `cfg_we_n` are both low for exactly the eight word cycles, with no gap, and `busy` is high in exactly those cycles.
- R6: `done` is high for exactly one cycle, the cycle after the last word, and `busy` is low in that cycle.
- R7: A trigger while `busy` is high has no effect on the word stream or its length.
- R8: With `SWAP=1`, every byte of each word is bit-reversed on `cfg_data` (the sync word shows as 0x5599AA66). With `SWAP=0`, words appear unchanged.
- R9: A trigger in the `done` cycle is accepted and starts a new run.
- R10: A reset during a run ends it at once, returning to the R1 idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle trigger |
| boot_addr | input | 32 | Start address of the next image |
| cfg_data | output | 32 | Configuration word |
| cfg_cs_n | output | 1 | Active-low chip enable |
| cfg_we_n | output | 1 | Active-low write enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The assertions check the following on every cycle:
- a run, once started, keeps its strobes low and its word index stepping by one until the last word, whatever the trigger does;
- the address is held stable for the whole run;
- the sync and reload-code words follow their predecessors;
- `done` is a single pulse after the end of `busy`.

Other behaviours need the bench's scenarios:
- the exact word order and the bit-reversed lane variant;
- capture of the address at the trigger edge;
- a trigger in the `done` cycle;
- reset in the middle of a run.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int NWORDS = 8;
  localparam int IDX_W  = $clog2(NWORDS);
  typedef logic [IDX_W-1:0] idx_t;

  localparam logic [31:0] W_DUMMY     = 32'hFFFF_FFFF;
  localparam logic [31:0] W_SYNC      = 32'hAA99_5566;
  localparam logic [31:0] W_NOOP      = 32'h2000_0000;
  localparam logic [31:0] W_HDR_BOOT  = 32'h3002_0001;
  localparam logic [31:0] W_HDR_CMD   = 32'h3000_8001;
  localparam logic [31:0] W_CMD_RELOAD = 32'h0000_000F;

  // Word at position idx of the reboot stream.
  function automatic logic [31:0] seq_word(input idx_t idx, input logic [31:0] addr);
    case (idx)
      3'd0:    seq_word = W_DUMMY;
      3'd1:    seq_word = W_SYNC;
      3'd2:    seq_word = W_NOOP;
      3'd3:    seq_word = W_HDR_BOOT;
      3'd4:    seq_word = addr;
      3'd5:    seq_word = W_HDR_CMD;
      3'd6:    seq_word = W_CMD_RELOAD;
      default: seq_word = W_NOOP;
    endcase
  endfunction

  // Reverse the bit order inside each byte.
  function automatic logic [31:0] byte_flip(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++)
        r[8*b+i] = w[8*b+7-i];
    return r;
  endfunction
endpackage

// File: rtl/wbs_ctrl.sv
module wbs_ctrl
  import wbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [31:0] addr_i,
  output logic        active_o,
  output idx_t        idx_o,
  output logic [31:0] addr_o,
  output logic        last_o,
  output logic        launch_o,
  output logic        done_o
);
  localparam idx_t LAST_IDX = idx_t'(NWORDS - 1);

  assign last_o   = active_o && (idx_o == LAST_IDX);
  assign launch_o = start_i && !active_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      idx_o    <= '0;
      addr_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (active_o) begin
        if (last_o) begin
          active_o <= 1'b0;
          idx_o    <= '0;
          done_o   <= 1'b1;
        end else begin
          idx_o <= idx_o + idx_t'(1);
        end
      end else if (launch_o) begin
        active_o <= 1'b1;
        idx_o    <= '0;
        addr_o   <= addr_i;
      end
    end
  end
endmodule

// File: rtl/wbs_word_sel.sv
module wbs_word_sel
  import wbs_pkg::*;
(
  input  logic        active_i,
  input  idx_t        idx_i,
  input  logic [31:0] addr_i,
  output logic [31:0] word_o
);
  always_comb word_o = active_i ? seq_word(idx_i, addr_i) : '0;
endmodule

// File: rtl/wbs_lane_order.sv
module wbs_lane_order #(
  parameter bit SWAP = 1'b0
) (
  input  logic [31:0] in_i,
  output logic [31:0] out_o
);
  generate
    if (SWAP) begin : g_flip
      for (genvar b = 0; b < 4; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
          assign out_o[8*b+i] = in_i[8*b+7-i];
        end
      end
    end else begin : g_pass
      assign out_o = in_i;
    end
  endgenerate
endmodule

// File: rtl/warmboot_seq.sv
module warmboot_seq
  import wbs_pkg::*;
#(
  parameter bit SWAP = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] boot_addr,
  output logic [31:0] cfg_data,
  output logic        cfg_cs_n,
  output logic        cfg_we_n,
  output logic        busy,
  output logic        done
);
  logic        active_w;
  idx_t        idx_w;
  logic [31:0] addr_q;
  logic        last_w;
  logic        launch_w;
  logic [31:0] word_w;

  wbs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .addr_i(boot_addr),
    .active_o(active_w), .idx_o(idx_w), .addr_o(addr_q),
    .last_o(last_w), .launch_o(launch_w), .done_o(done)
  );

  wbs_word_sel u_sel (
    .active_i(active_w), .idx_i(idx_w), .addr_i(addr_q), .word_o(word_w)
  );

  wbs_lane_order #(.SWAP(SWAP)) u_lane (.in_i(word_w), .out_o(cfg_data));

  assign busy     = active_w;
  assign cfg_cs_n = ~active_w;
  assign cfg_we_n = ~active_w;
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker
  import wbs_pkg::*;
#(
  parameter bit SWAP = 1'b0
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        cs_n,
  input logic        we_n,
  input logic [31:0] data,
  input idx_t        idx,
  input logic        last,
  input logic        launch,
  input logic [31:0] addr_q
);
  function automatic logic [31:0] lane(input logic [31:0] w);
    return SWAP ? byte_flip(w) : w;
  endfunction

  a_r5_launch_busy: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy && idx == '0);
  a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
  a_r5_strobes: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!cs_n && !we_n));
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> idx == $past(idx) + idx_t'(1));
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(addr_q));
  a_r2_sync_second: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == idx_t'(0)) |=> data == lane(W_SYNC));
  a_r4_reload_code: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == idx_t'(5)) |=> data == lane(W_CMD_RELOAD));
  a_r6_done_after: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind warmboot_seq wbs_checker #(.SWAP(SWAP)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .cs_n(cfg_cs_n), .we_n(cfg_we_n), .data(cfg_data), .idx(idx_w),
  .last(last_w), .launch(launch_w), .addr_q(addr_q)
);

// File: tb/test_warmboot_seq.sv
module test_warmboot_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] boot_addr = '0;
  logic [31:0] d0, d1;
  logic cs0, we0, bz0, dn0, cs1, we1, bz1, dn1;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warmboot_seq #(.SWAP(1'b0)) i_warmboot_seq (
    .clk(clk), .rst(rst), .start(start), .boot_addr(boot_addr),
    .cfg_data(d0), .cfg_cs_n(cs0), .cfg_we_n(we0), .busy(bz0), .done(dn0));
  warmboot_seq #(.SWAP(1'b1)) i_warmboot_seq_swap (
    .clk(clk), .rst(rst), .start(start), .boot_addr(boot_addr),
    .cfg_data(d1), .cfg_cs_n(cs1), .cfg_we_n(we1), .busy(bz1), .done(dn1));

  // Behavioural reference: position of the word on the bus (-1 idle)
  int          m_pos = -1;
  logic [31:0] m_addr = '0;
  bit          m_done = 1'b0;

  function automatic logic [31:0] ref_word(int p, logic [31:0] a);
    logic [31:0] tbl [8];
    tbl = '{32'hFFFFFFFF, 32'hAA995566, 32'h20000000, 32'h30020001,
            a, 32'h30008001, 32'h0000000F, 32'h20000000};
    return tbl[p];
  endfunction

  function automatic logic [31:0] rev_bytes(logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = w[(k/8)*8 + 7 - (k%8)];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = -1; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_pos >= 0) begin
        if (m_pos == 7) begin m_pos = -1; m_done = 1'b1; end
        else m_pos = m_pos + 1;
      end else if (start) begin
        m_pos = 0; m_addr = boot_addr;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison of both instances against the reference
  logic [31:0] q0 [$];
  logic [31:0] q1 [$];
  always @(negedge clk) begin
    logic [31:0] e;
    string tag;
    cyc++;
    e   = (m_pos >= 0) ? ref_word(m_pos, m_addr) : 32'h0;
    tag = m_done ? "R6" : (m_pos >= 0 ? "R2" : "R1");
    chk(d0 == e, tag, d0, e);
    chk(d1 == rev_bytes(e), "R8", d1, rev_bytes(e));
    chk({cs0, we0, bz0} == {m_pos < 0, m_pos < 0, m_pos >= 0}, "R5",
        {29'b0, cs0, we0, bz0}, {29'b0, m_pos < 0, m_pos < 0, m_pos >= 0});
    chk({cs1, bz1} == {cs0, bz0} && we1 == we0, "R5",
        {29'b0, cs1, we1, bz1}, {29'b0, cs0, we0, bz0});
    chk(dn0 == m_done && dn1 == m_done, "R6",
        {30'b0, dn1, dn0}, {30'b0, m_done, m_done});
    if (!cs0) q0.push_back(d0);
    if (!cs1) q1.push_back(d1);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(logic [31:0] a);
    @(negedge clk); boot_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk(cs0 && we0 && !bz0 && !dn0 && d0 == 0, "R1", d0, 32'h0);
    rst = 1'b0;
    tick(2);

    // Basic run
    q0.delete(); q1.delete();
    fire(32'h0040_0000);
    tick(10);
    chk(q0.size() == 8, "R5", q0.size(), 8);
    if (q0.size() == 8) begin
      chk(q0[4] == 32'h0040_0000, "R3", q0[4], 32'h0040_0000);
      chk(q0[5][17:13] == 5'h04, "R4", {27'b0, q0[5][17:13]}, 32'h4);
      chk(q0[5][31:27] == 5'b00110, "R4", {27'b0, q0[5][31:27]}, 32'h6);
      chk(q0[6] == 32'hF, "R4", q0[6], 32'hF);
      chk(q0[1] == 32'hAA995566, "R2", q0[1], 32'hAA995566);
    end
    if (q1.size() >= 2)
      chk(q1[1] == 32'h5599AA66, "R8", q1[1], 32'h5599AA66);

    // Address changes and triggers during the run
    q0.delete();
    fire(32'h1234_5678);
    boot_addr = 32'hDEAD_BEEF; start = 1'b1;
    tick(3);
    start = 1'b0;
    tick(10);
    chk(q0.size() == 8, "R7", q0.size(), 8);
    if (q0.size() == 8) chk(q0[4] == 32'h1234_5678, "R3", q0[4], 32'h1234_5678);

    // Trigger in the done cycle
    fire(32'h0000_1000);
    while (!dn0) tick();
    boot_addr = 32'h0000_2000; start = 1'b1;
    tick();
    start = 1'b0;
    chk(bz0 == 1'b1, "R9", {31'b0, bz0}, 32'h1);
    tick(10);

    // Reset mid-run
    fire(32'h0080_0000);
    tick(2);
    rst = 1'b1;
    tick();
    chk(cs0 && we0 && !bz0 && d0 == 0, "R10", {31'b0, bz0}, 32'h0);
    rst = 1'b0;
    tick(3);
    chk(cs0 && !bz0 && !dn0, "R10", {31'b0, bz0}, 32'h0);

    // Another address pattern, swapped lanes
    q1.delete();
    fire(32'hA5C3_0F81);
    tick(10);
    if (q1.size() == 8)
      chk(q1[4] == rev_bytes(32'hA5C3_0F81), "R8", q1[4], rev_bytes(32'hA5C3_0F81));
    else chk(1'b0, "R8", q1.size(), 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule